// File: doc/BRIEF.md
# Complementary Dimension-Ordered Mesh Router

This block is the router of one tile in a two-dimensional mesh. It holds two routing planes that share nothing. The request plane forwards each flit along the X axis until the column matches. It then forwards the flit along the Y axis. The response plane forwards along Y first and then along X. A reply injected at the destination therefore retraces the mirror path of its request and never competes with requests for buffers or links.

Each plane has five ports: local, north, south, east and west. Each port has a 100-bit flit and a valid/ready handshake in both directions. The tile's own column and row come from two configuration inputs. The destination is read from the top ten bits of every flit. Each input has a one-entry buffer. Each output has its own round-robin arbiter, which locks its choice while the downstream side stalls. The router never moves a flit from one plane to the other. Turning a request into a response is left to the tile's local endpoint.

Top module: `mesh_router`

## Requirements
- R1: While reset is high and in the first cycle after it, every `*_in_ready` bit is 1 and every `*_out_valid` bit is 0.
- R2: Port index 0 is local, 1 is north, 2 is south, 3 is east and 4 is west. The destination column is flit bits 99:95 and the destination row is bits 94:90. East means a larger column and north means a larger row. On the request plane, a flit whose column differs from `tile_x` leaves east or west, whatever its row.
- R3: On the request plane, a flit whose column equals `tile_x` but whose row differs leaves north when its row is larger than `tile_y` and south when it is smaller.
- R4: On either plane, a flit addressed to (`tile_x`, `tile_y`) is shown on local output 0 in the cycle after the input handshake, with its data unchanged.
- R5: On the response plane, a flit whose row differs leaves north or south, whatever its column. Only when the rows match does it leave east or west, or local when the column also matches.
- R6: After an input accepts a flit, its ready stays low until that flit has left through an output. Ready is high again in the cycle after the flit leaves.
- R7: While an output shows valid with ready low, it keeps valid high and its data unchanged in the next cycle.
- R8: Each output's arbiter starts its search at input 0 after reset. After a flit from input i leaves, the next search starts at input i+1 and wraps from 4 to 0.
- R9: A flit entering one plane only ever appears on the outputs of that same plane.
- R10: A stalled output does not delay flits held in other inputs that are headed to other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tile_x | input | 5 | Column of this tile |
| tile_y | input | 5 | Row of this tile |
| req_in_valid | input | 5 | Request plane input valid, one bit per port |
| req_in_flit | input | 5x100 | Request plane input flits |
| req_in_ready | output | 5 | Request plane input ready |
| req_out_valid | output | 5 | Request plane output valid |
| req_out_flit | output | 5x100 | Request plane output flits |
| req_out_ready | input | 5 | Request plane downstream ready |
| rsp_in_valid | input | 5 | Response plane input valid |
| rsp_in_flit | input | 5x100 | Response plane input flits |
| rsp_in_ready | output | 5 | Response plane input ready |
| rsp_out_valid | output | 5 | Response plane output valid |
| rsp_out_flit | output | 5x100 | Response plane output flits |
| rsp_out_ready | input | 5 | Response plane downstream ready |

## Verification
The assertions assume that `tile_x` and `tile_y` stay constant after reset, because the route checks compare each outgoing flit against the current coordinates. The bench sets the coordinates once, before reset is released, and never changes them. The assertions also assume that stalls come only from the downstream ready bits. The bench creates every stall by pulling an output's ready low and drives each input's valid for exactly one accepted cycle.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;

    localparam int COORD_W = 5;
    localparam int FLIT_W  = 100;
    localparam int NPORT   = 5;
    localparam int PORT_W  = 3;
    localparam int DY_LSB  = FLIT_W - 2 * COORD_W;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [FLIT_W-1:0]  flit_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } tile_pos_t;

    typedef enum logic [PORT_W-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_SOUTH = 3'd2,
        P_EAST  = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef enum logic {
        ORD_XY = 1'b0,
        ORD_YX = 1'b1
    } dim_order_e;

    function automatic tile_pos_t flit_dest(flit_t f);
        tile_pos_t d;
        d.x = f[FLIT_W-1 -: COORD_W];
        d.y = f[DY_LSB +: COORD_W];
        return d;
    endfunction

    function automatic port_e next_hop(dim_order_e ord, tile_pos_t here, tile_pos_t dst);
        port_e xdir;
        port_e ydir;
        logic  xdone;
        logic  ydone;
        xdir  = (dst.x > here.x) ? P_EAST : P_WEST;
        ydir  = (dst.y > here.y) ? P_NORTH : P_SOUTH;
        xdone = (dst.x == here.x);
        ydone = (dst.y == here.y);
        if (xdone && ydone) return P_LOCAL;
        if (ord == ORD_XY)  return xdone ? ydir : xdir;
        return ydone ? xdir : ydir;
    endfunction

endpackage

// File: rtl/mesh_in_slot.sv
module mesh_in_slot
    import mesh_rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  flit_t in_data,
    output logic  in_ready,
    output logic  held,
    output flit_t held_data,
    input  logic  take
);

    logic  full_q;
    flit_t data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (!full_q && in_valid) begin
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!full_q && in_valid) begin
            data_q <= in_data;
        end
    end

    assign in_ready  = !full_q;
    assign held      = full_q;
    assign held_data = data_q;

endmodule

// File: rtl/mesh_rr_arb.sv
module mesh_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         fire,
    output logic [N-1:0] grant
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;
    logic          locked_q;
    logic [N-1:0]  lock_oh_q;
    logic [IW-1:0] lock_idx_q;
    logic [N-1:0]  pick_oh;
    logic [IW-1:0] pick_idx;
    logic [IW-1:0] gnt_idx;
    logic          found;

    always_comb begin
        int idx;
        pick_oh  = '0;
        pick_idx = '0;
        found    = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found         = 1'b1;
                pick_oh[idx]  = 1'b1;
                pick_idx      = IW'(idx);
            end
        end
    end

    assign grant   = locked_q ? lock_oh_q  : pick_oh;
    assign gnt_idx = locked_q ? lock_idx_q : pick_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            locked_q   <= 1'b0;
            lock_oh_q  <= '0;
            lock_idx_q <= '0;
        end else if (fire) begin
            locked_q <= 1'b0;
            ptr_q    <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
        end else if (found && !locked_q) begin
            locked_q   <= 1'b1;
            lock_oh_q  <= pick_oh;
            lock_idx_q <= pick_idx;
        end
    end

endmodule

// File: rtl/mesh_plane.sv
module mesh_plane
    import mesh_rt_pkg::*;
#(
    parameter dim_order_e ORDER = ORD_XY
) (
    input  logic                          clk,
    input  logic                          rst,
    input  tile_pos_t                     here,
    input  logic [NPORT-1:0]              in_valid,
    input  logic [NPORT-1:0][FLIT_W-1:0]  in_data,
    output logic [NPORT-1:0]              in_ready,
    output logic [NPORT-1:0]              out_valid,
    output logic [NPORT-1:0][FLIT_W-1:0]  out_data,
    input  logic [NPORT-1:0]              out_ready
);

    logic  [NPORT-1:0]             held;
    flit_t                         held_data [NPORT];
    port_e                         hop       [NPORT];
    logic  [NPORT-1:0]             take;
    logic  [NPORT-1:0][NPORT-1:0]  want;
    logic  [NPORT-1:0][NPORT-1:0]  grant;
    logic  [NPORT-1:0]             fire;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        mesh_in_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[i]),
            .in_data   (in_data[i]),
            .in_ready  (in_ready[i]),
            .held      (held[i]),
            .held_data (held_data[i]),
            .take      (take[i])
        );
        assign hop[i] = next_hop(ORDER, here, flit_dest(held_data[i]));
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                want[o][i] = held[i] && (hop[i] == port_e'(o));
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        mesh_rr_arb #(.N(NPORT)) u_arb (
            .clk   (clk),
            .rst   (rst),
            .req   (want[o]),
            .fire  (fire[o]),
            .grant (grant[o])
        );
        assign out_valid[o] = |want[o];
        assign fire[o]      = out_valid[o] && out_ready[o];
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            out_data[o] = '0;
            for (int i = 0; i < NPORT; i++) begin
                out_data[o] = out_data[o] | (held_data[i] & {FLIT_W{grant[o][i]}});
            end
        end
    end

    always_comb begin
        take = '0;
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                take[i] = take[i] | (fire[o] & grant[o][i]);
            end
        end
    end

endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_rt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [COORD_W-1:0]            tile_x,
    input  logic [COORD_W-1:0]            tile_y,
    input  logic [NPORT-1:0]              req_in_valid,
    input  logic [NPORT-1:0][FLIT_W-1:0]  req_in_flit,
    output logic [NPORT-1:0]              req_in_ready,
    output logic [NPORT-1:0]              req_out_valid,
    output logic [NPORT-1:0][FLIT_W-1:0]  req_out_flit,
    input  logic [NPORT-1:0]              req_out_ready,
    input  logic [NPORT-1:0]              rsp_in_valid,
    input  logic [NPORT-1:0][FLIT_W-1:0]  rsp_in_flit,
    output logic [NPORT-1:0]              rsp_in_ready,
    output logic [NPORT-1:0]              rsp_out_valid,
    output logic [NPORT-1:0][FLIT_W-1:0]  rsp_out_flit,
    input  logic [NPORT-1:0]              rsp_out_ready
);

    tile_pos_t here;
    assign here.x = tile_x;
    assign here.y = tile_y;

    mesh_plane #(.ORDER(ORD_XY)) u_req_plane (
        .clk       (clk),
        .rst       (rst),
        .here      (here),
        .in_valid  (req_in_valid),
        .in_data   (req_in_flit),
        .in_ready  (req_in_ready),
        .out_valid (req_out_valid),
        .out_data  (req_out_flit),
        .out_ready (req_out_ready)
    );

    mesh_plane #(.ORDER(ORD_YX)) u_rsp_plane (
        .clk       (clk),
        .rst       (rst),
        .here      (here),
        .in_valid  (rsp_in_valid),
        .in_data   (rsp_in_flit),
        .in_ready  (rsp_in_ready),
        .out_valid (rsp_out_valid),
        .out_data  (rsp_out_flit),
        .out_ready (rsp_out_ready)
    );

endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk
    import mesh_rt_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [COORD_W-1:0]            tile_x,
    input logic [COORD_W-1:0]            tile_y,
    input logic [NPORT-1:0]              req_in_valid,
    input logic [NPORT-1:0][FLIT_W-1:0]  req_in_flit,
    input logic [NPORT-1:0]              req_in_ready,
    input logic [NPORT-1:0]              req_out_valid,
    input logic [NPORT-1:0][FLIT_W-1:0]  req_out_flit,
    input logic [NPORT-1:0]              req_out_ready,
    input logic [NPORT-1:0]              rsp_in_valid,
    input logic [NPORT-1:0][FLIT_W-1:0]  rsp_in_flit,
    input logic [NPORT-1:0]              rsp_in_ready,
    input logic [NPORT-1:0]              rsp_out_valid,
    input logic [NPORT-1:0][FLIT_W-1:0]  rsp_out_flit,
    input logic [NPORT-1:0]              rsp_out_ready
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // R7
        req_hold_chk: assert property (@(posedge clk) disable iff (rst)
            req_out_valid[p] && !req_out_ready[p] |=> req_out_valid[p] && $stable(req_out_flit[p]));
        // R7
        rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_out_valid[p] && !rsp_out_ready[p] |=> rsp_out_valid[p] && $stable(rsp_out_flit[p]));
        // R6
        req_slot_full_chk: assert property (@(posedge clk) disable iff (rst)
            req_in_valid[p] && req_in_ready[p] |=> !req_in_ready[p]);
        // R6
        rsp_slot_full_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_in_valid[p] && rsp_in_ready[p] |=> !rsp_in_ready[p]);
    end

    // R4
    req_local_dest_chk: assert property (@(posedge clk) disable iff (rst)
        req_out_valid[0] |-> (req_out_flit[0][FLIT_W-1 -: COORD_W] == tile_x) &&
                             (req_out_flit[0][DY_LSB +: COORD_W] == tile_y));
    // R4
    rsp_local_dest_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_out_valid[0] |-> (rsp_out_flit[0][FLIT_W-1 -: COORD_W] == tile_x) &&
                             (rsp_out_flit[0][DY_LSB +: COORD_W] == tile_y));
    // R2
    req_east_chk: assert property (@(posedge clk) disable iff (rst)
        req_out_valid[3] |-> req_out_flit[3][FLIT_W-1 -: COORD_W] > tile_x);
    // R3
    req_north_chk: assert property (@(posedge clk) disable iff (rst)
        req_out_valid[1] |-> (req_out_flit[1][FLIT_W-1 -: COORD_W] == tile_x) &&
                             (req_out_flit[1][DY_LSB +: COORD_W] > tile_y));
    // R5
    rsp_east_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_out_valid[3] |-> (rsp_out_flit[3][DY_LSB +: COORD_W] == tile_y) &&
                             (rsp_out_flit[3][FLIT_W-1 -: COORD_W] > tile_x));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (req_out_valid == '0) && (rsp_out_valid == '0) &&
                       (&req_in_ready) && (&rsp_in_ready));

endmodule

bind mesh_router mesh_router_chk u_chk (.*);

// File: tb/mesh_router_test.sv
module mesh_router_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [4:0]         tile_x = 5'd10;
    logic [4:0]         tile_y = 5'd20;
    logic [4:0]         req_in_valid = '0;
    logic [4:0][99:0]   req_in_flit = '0;
    logic [4:0]         req_in_ready;
    logic [4:0]         req_out_valid;
    logic [4:0][99:0]   req_out_flit;
    logic [4:0]         req_out_ready = '1;
    logic [4:0]         rsp_in_valid = '0;
    logic [4:0][99:0]   rsp_in_flit = '0;
    logic [4:0]         rsp_in_ready;
    logic [4:0]         rsp_out_valid;
    logic [4:0][99:0]   rsp_out_flit;
    logic [4:0]         rsp_out_ready = '1;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mesh_router uut (
        .clk(clk), .rst(rst), .tile_x(tile_x), .tile_y(tile_y),
        .req_in_valid(req_in_valid), .req_in_flit(req_in_flit), .req_in_ready(req_in_ready),
        .req_out_valid(req_out_valid), .req_out_flit(req_out_flit), .req_out_ready(req_out_ready),
        .rsp_in_valid(rsp_in_valid), .rsp_in_flit(rsp_in_flit), .rsp_in_ready(rsp_in_ready),
        .rsp_out_valid(rsp_out_valid), .rsp_out_flit(rsp_out_flit), .rsp_out_ready(rsp_out_ready)
    );

    // {plane(0 req,1 rsp), in port, dest x, dest y, expected out port}; tile at (10,20)
    localparam int NV = 13;
    localparam logic [16:0] VECS [NV] = '{
        {1'b0, 3'd4, 5'd15, 5'd3,  3'd3},
        {1'b0, 3'd3, 5'd2,  5'd30, 3'd4},
        {1'b0, 3'd4, 5'd10, 5'd25, 3'd1},
        {1'b0, 3'd1, 5'd10, 5'd5,  3'd2},
        {1'b0, 3'd1, 5'd10, 5'd20, 3'd0},
        {1'b0, 3'd0, 5'd31, 5'd0,  3'd3},
        {1'b0, 3'd0, 5'd0,  5'd31, 3'd4},
        {1'b1, 3'd0, 5'd15, 5'd3,  3'd2},
        {1'b1, 3'd3, 5'd2,  5'd30, 3'd1},
        {1'b1, 3'd2, 5'd15, 5'd20, 3'd3},
        {1'b1, 3'd1, 5'd0,  5'd20, 3'd4},
        {1'b1, 3'd4, 5'd10, 5'd20, 3'd0},
        {1'b1, 3'd0, 5'd10, 5'd31, 3'd1}
    };

    function automatic logic [99:0] mk(logic [4:0] dx, logic [4:0] dy, logic [15:0] tag);
        return {dx, dy, 74'd0, tag};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [99:0] act, input logic [99:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(logic net, logic [2:0] ep);
        if (ep == 3'd0) return "R4";
        if (net) return "R5";
        if (ep == 3'd3 || ep == 3'd4) return "R2";
        return "R3";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [99:0] fa, fb;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(req_out_valid == 5'd0 && rsp_out_valid == 5'd0, "R1", {req_out_valid, rsp_out_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_in_ready == 5'h1f && rsp_in_ready == 5'h1f, "R1", {req_in_ready, rsp_in_ready}, 10'h3ff);
        chk(req_out_valid == 5'd0 && rsp_out_valid == 5'd0, "R1", {req_out_valid, rsp_out_valid}, 0);

        // table walk: R2 R3 R4 R5 R6 R9
        for (int v = 0; v < NV; v++) begin
            logic       net;
            logic [2:0] ip, ep;
            logic [4:0] dx, dy, ov, other;
            logic [99:0] f, od;
            {net, ip, dx, dy, ep} = VECS[v];
            f = mk(dx, dy, 16'(v + 16'h100));
            if (net) begin rsp_in_valid[ip] = 1'b1; rsp_in_flit[ip] = f; end
            else     begin req_in_valid[ip] = 1'b1; req_in_flit[ip] = f; end
            @(negedge clk);
            req_in_valid = '0;
            rsp_in_valid = '0;
            ov    = net ? rsp_out_valid : req_out_valid;
            other = net ? req_out_valid : rsp_out_valid;
            od    = net ? rsp_out_flit[ep] : req_out_flit[ep];
            chk(ov == (5'd1 << ep), tag_of(net, ep), 100'(ov), 100'(5'd1 << ep));
            chk(od == f, tag_of(net, ep), od, f);
            chk(other == 5'd0, "R9", 100'(other), 0);
            chk((net ? rsp_in_ready[ip] : req_in_ready[ip]) == 1'b0, "R6", 1, 0);
            @(negedge clk);
            ov = net ? rsp_out_valid : req_out_valid;
            chk(ov == 5'd0, "R6", 100'(ov), 0);
            chk((net ? rsp_in_ready[ip] : req_in_ready[ip]) == 1'b1, "R6", 0, 1);
        end

        // R7 and R10: stalled east output, local traffic still flows
        fa = mk(5'd20, 5'd20, 16'hA1);
        fb = mk(5'd10, 5'd20, 16'hB2);
        req_out_ready[3] = 1'b0;
        req_in_valid[0] = 1'b1; req_in_flit[0] = fa;
        @(negedge clk);
        req_in_valid[0] = 1'b0;
        chk(req_out_valid[3] && req_out_flit[3] == fa, "R7", req_out_flit[3], fa);
        req_in_valid[1] = 1'b1; req_in_flit[1] = fb;
        @(negedge clk);
        req_in_valid[1] = 1'b0;
        chk(req_out_valid[0] && req_out_flit[0] == fb, "R10", req_out_flit[0], fb);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req_out_valid[3] && req_out_flit[3] == fa, "R7", req_out_flit[3], fa);
            chk(req_in_ready[0] == 1'b0, "R6", 1, 0);
        end
        req_out_ready[3] = 1'b1;
        @(negedge clk);
        chk(req_out_valid == 5'd0, "R7", 100'(req_out_valid), 0);

        // R8: after a flit from east leaves local, west beats north
        req_in_valid[3] = 1'b1; req_in_flit[3] = mk(5'd10, 5'd20, 16'hC3);
        @(negedge clk);
        req_in_valid[3] = 1'b0;
        @(negedge clk);
        req_out_ready[0] = 1'b0;
        fa = mk(5'd10, 5'd20, 16'hD1);
        fb = mk(5'd10, 5'd20, 16'hD4);
        req_in_valid[1] = 1'b1; req_in_flit[1] = fa;
        req_in_valid[4] = 1'b1; req_in_flit[4] = fb;
        @(negedge clk);
        req_in_valid = '0;
        chk(req_out_valid[0] && req_out_flit[0] == fb, "R8", req_out_flit[0], fb);
        @(negedge clk);
        chk(req_out_flit[0] == fb, "R8", req_out_flit[0], fb);
        req_out_ready[0] = 1'b1;
        @(negedge clk);
        chk(req_out_valid[0] && req_out_flit[0] == fa, "R8", req_out_flit[0], fa);
        @(negedge clk);
        chk(req_out_valid == 5'd0, "R8", 100'(req_out_valid), 0);

        // R9: both planes at once, each flit stays in its own plane
        fa = mk(5'd10, 5'd20, 16'hE1);
        fb = mk(5'd10, 5'd20, 16'hE2);
        req_in_valid[2] = 1'b1; req_in_flit[2] = fa;
        rsp_in_valid[2] = 1'b1; rsp_in_flit[2] = fb;
        @(negedge clk);
        req_in_valid = '0;
        rsp_in_valid = '0;
        chk(req_out_valid == 5'd1 && req_out_flit[0] == fa, "R9", req_out_flit[0], fa);
        chk(rsp_out_valid == 5'd1 && rsp_out_flit[0] == fb, "R9", rsp_out_flit[0], fb);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule